// File: doc/BRIEF.md
# OTP Packet Read Controller

This block is a register-mapped read path for a one-time-programmable word array that holds a chain of variable-length packets. Each packet opens with one header word. The payload length in words sits in header bits 15:8, and the payload words follow the header directly. A header whose length field is zero ends the chain.

Software places a word address in the mode register and then writes the start bit of the control register. The controller walks the chain from word 0. Each packet's next header lies at its header position plus its length plus 2. The walk stops at the packet whose span covers the requested address. The controller stages that header in the header register and copies the payload into a local buffer. Software then reads the payload through an index register and a self-advancing data register.

The array sits outside the block as a synchronous ROM with one cycle of read latency. The bus is a single-cycle request with a registered read return one cycle later.

Top module: `otp_pkt_rd_ctrl`

## Requirements
- R1: After reset, reads of the mode (0x4), index (0x8), status (0xC) and header (0x20) registers all return 0.
- R2: The requested word address is held in bits 31:16 of the mode register (0x4) and reads back there. Bits 15:0 read 0.
- R3: A write to the control register (0x0) with bit 6 set sets the busy flag (status bit 6) from the next cycle. A control write with bit 6 clear has no effect.
- R4: Every address from a packet's first word up to the word before the next packet's header selects that packet. Its header appears at 0x20 when busy clears. The header length field is bits 15:8, and the next header lies at header position + length + 2.
- R5: Writing the index register (0x8) sets the payload index. Each read of the data register (0x24) returns payload word [index] and then adds one to the index, which reads back at 0x8.
- R6: Data-register reads with an index at or beyond the payload length return 0.
- R7: If the walk reaches a zero-length header before covering the address, the header register reads 0, status bit 0 reads 1 and busy clears. The next load clears bit 0.
- R8: Busy stays set for exactly 2k + L + 1 cycles when the packet is found as the k-th header with length L. On an error after reading k headers, busy stays set for 2k cycles.
- R9: While busy, writes to the control and mode registers are ignored. The load in progress keeps the address latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| rom_addr_o | output | ROM_AW | Word address to the OTP array |
| rom_rdata_i | input | 32 | Array word, returned one cycle after rom_addr_o |

## Verification
The assertions assume that the array answers every address exactly one cycle later. They also assume that a register access lasts a single cycle and never reads and writes in the same cycle. The bench models the array as a registered lookup driven by rom_addr_o. It issues one request per cycle, driven on the falling edge. It reprograms the array image only while the controller is idle, so the chain never changes during a walk.

// File: rtl/otp_pkt_pkg.sv
package otp_pkt_pkg;
  localparam int unsigned REQ_AW = 16;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_MODE   = 8'h04;
  localparam logic [7:0] OFS_INDEX  = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  localparam logic [7:0] OFS_HDR    = 8'h20;
  localparam logic [7:0] OFS_DATA   = 8'h24;

  localparam int unsigned START_BIT = 6;
  localparam int unsigned BUSY_BIT  = 6;
  localparam int unsigned ERR_BIT   = 0;
  localparam int unsigned LEN_LSB   = 8;

  typedef enum logic [1:0] {
    W_IDLE,
    W_HADDR,
    W_HDATA,
    W_COPY
  } walk_st_e;
endpackage

// File: rtl/otp_pkt_buf.sv
module otp_pkt_buf #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [31:0]   wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/otp_pkt_walker.sv
module otp_pkt_walker
  import otp_pkt_pkg::*;
#(
  parameter int unsigned ARRAY_WORDS = 2816,
  parameter int unsigned SIZE_W = 8,
  localparam int unsigned ROM_AW = $clog2(ARRAY_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REQ_AW-1:0] target_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [31:0]       rom_rdata_i,
  output logic              busy_o,
  output logic              err_o,
  output logic [31:0]       hdr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              buf_we_o,
  output logic [SIZE_W-1:0] buf_widx_o,
  output logic [31:0]       buf_wdata_o
);
  localparam logic [REQ_AW-1:0] LIMIT = REQ_AW'(ARRAY_WORDS);

  walk_st_e          st_q;
  logic [REQ_AW-1:0] pos_q, tgt_q;
  logic [SIZE_W-1:0] iss_q, pend_idx_q;
  logic              pend_v_q;
  logic [SIZE_W-1:0] len_w;
  logic [REQ_AW-1:0] nxt_w, cpy_addr_w;

  assign len_w      = rom_rdata_i[LEN_LSB +: SIZE_W];
  assign nxt_w      = pos_q + REQ_AW'(len_w) + REQ_AW'(2);
  assign cpy_addr_w = pos_q + REQ_AW'(iss_q) + REQ_AW'(1);
  assign rom_addr_o = (st_q == W_COPY) ? cpy_addr_w[ROM_AW-1:0] : pos_q[ROM_AW-1:0];

  assign buf_we_o    = (st_q == W_COPY) && pend_v_q;
  assign buf_widx_o  = pend_idx_q;
  assign buf_wdata_o = rom_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= W_IDLE;
      pos_q      <= '0;
      tgt_q      <= '0;
      iss_q      <= '0;
      pend_idx_q <= '0;
      pend_v_q   <= 1'b0;
      busy_o     <= 1'b0;
      err_o      <= 1'b0;
      hdr_o      <= '0;
      size_o     <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          st_q   <= W_HADDR;
          busy_o <= 1'b1;
          err_o  <= 1'b0;
          pos_q  <= '0;
          tgt_q  <= target_i;
        end
        W_HADDR: begin
          if (pos_q >= LIMIT) begin
            // chain ran off the array
            st_q   <= W_IDLE;
            busy_o <= 1'b0;
            err_o  <= 1'b1;
            hdr_o  <= '0;
            size_o <= '0;
          end else begin
            st_q <= W_HDATA;
          end
        end
        W_HDATA: begin
          if (len_w == '0) begin
            st_q   <= W_IDLE;
            busy_o <= 1'b0;
            err_o  <= 1'b1;
            hdr_o  <= '0;
            size_o <= '0;
          end else if (tgt_q < nxt_w) begin
            st_q     <= W_COPY;
            hdr_o    <= rom_rdata_i;
            size_o   <= len_w;
            iss_q    <= '0;
            pend_v_q <= 1'b0;
          end else begin
            pos_q <= nxt_w;
            st_q  <= W_HADDR;
          end
        end
        W_COPY: begin
          // one word issued per cycle, captured the cycle after
          if (iss_q < size_o) begin
            pend_v_q   <= 1'b1;
            pend_idx_q <= iss_q;
            iss_q      <= iss_q + 1'b1;
          end else begin
            pend_v_q <= 1'b0;
          end
          if (pend_v_q && pend_idx_q == size_o - 1'b1) begin
            st_q   <= W_IDLE;
            busy_o <= 1'b0;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otp_pkt_rd_ctrl.sv
module otp_pkt_rd_ctrl
  import otp_pkt_pkg::*;
#(
  parameter int unsigned ARRAY_WORDS = 2816,
  parameter int unsigned SIZE_W = 8,
  localparam int unsigned ROM_AW = $clog2(ARRAY_WORDS),
  localparam int unsigned IDX_W = SIZE_W + 1,
  localparam int unsigned BUF_DEPTH = 1 << SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [31:0]       rom_rdata_i
);
  logic [REQ_AW-1:0] mode_q;
  logic [IDX_W-1:0]  idx_q;
  logic [31:0]       rdata_q;
  logic              busy, err;
  logic [31:0]       hdr_q;
  logic [SIZE_W-1:0] size_q;
  logic              buf_we;
  logic [SIZE_W-1:0] buf_widx;
  logic [31:0]       buf_wdata, buf_rdata;
  logic              wr_w, rd_w, start_w, in_pay_w;
  logic              unused_w;

  assign wr_w     = req_i && we_i;
  assign rd_w     = req_i && !we_i;
  assign start_w  = wr_w && (addr_i == OFS_CTRL) && wdata_i[START_BIT] && !busy;
  assign in_pay_w = idx_q < IDX_W'(size_q);
  assign unused_w = ^{wdata_i[15:IDX_W]};

  otp_pkt_walker #(.ARRAY_WORDS(ARRAY_WORDS), .SIZE_W(SIZE_W)) u_walk (
    .clk_i, .rst_ni,
    .start_i     (start_w),
    .target_i    (mode_q),
    .rom_addr_o,
    .rom_rdata_i,
    .busy_o      (busy),
    .err_o       (err),
    .hdr_o       (hdr_q),
    .size_o      (size_q),
    .buf_we_o    (buf_we),
    .buf_widx_o  (buf_widx),
    .buf_wdata_o (buf_wdata)
  );

  otp_pkt_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk_i,
    .we_i    (buf_we),
    .widx_i  (buf_widx),
    .wdata_i (buf_wdata),
    .ridx_i  (idx_q[SIZE_W-1:0]),
    .rdata_o (buf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_w && addr_i == OFS_MODE && !busy) mode_q <= wdata_i[31:16];
      if (wr_w && addr_i == OFS_INDEX) begin
        idx_q <= wdata_i[IDX_W-1:0];
      end else if (rd_w && addr_i == OFS_DATA && idx_q != '1) begin
        idx_q <= idx_q + 1'b1;
      end
      if (rd_w) begin
        unique case (addr_i)
          OFS_MODE:   rdata_q <= {mode_q, 16'h0};
          OFS_INDEX:  rdata_q <= 32'(idx_q);
          OFS_STATUS: rdata_q <= (32'(busy) << BUSY_BIT) | (32'(err) << ERR_BIT);
          OFS_HDR:    rdata_q <= hdr_q;
          OFS_DATA:   rdata_q <= in_pay_w ? buf_rdata : 32'h0;
          default:    rdata_q <= 32'h0;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/otp_pkt_rd_ctrl_chk.sv
module otp_pkt_rd_ctrl_chk
  import otp_pkt_pkg::*;
#(
  parameter int unsigned SIZE_W = 8,
  localparam int unsigned IDX_W = SIZE_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [7:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              busy,
  input logic              err,
  input logic [31:0]       hdr_q,
  input logic [REQ_AW-1:0] mode_q,
  input logic [IDX_W-1:0]  idx_q,
  input logic [SIZE_W-1:0] size_q
);
  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_CTRL && wdata_i[START_BIT] && !busy) |=> busy);

  // R7
  err_hdr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |-> (hdr_q == 32'h0 && !busy));

  // R7
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !err);

  // R5
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_DATA && idx_q != '1) |=> idx_q == $past(idx_q) + 1'b1);

  // R6
  past_end_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_DATA && idx_q >= IDX_W'(size_q)) |=> rdata_o == 32'h0);

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && req_i && we_i && addr_i == OFS_MODE) |=> $stable(mode_q));
endmodule

bind otp_pkt_rd_ctrl otp_pkt_rd_ctrl_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .busy    (busy),
  .err     (err),
  .hdr_q   (hdr_q),
  .mode_q  (mode_q),
  .idx_q   (idx_q),
  .size_q  (size_q)
);

// File: tb/otp_pkt_rd_ctrl_tb_top.sv
module otp_pkt_rd_ctrl_tb_top;
  localparam int WORDS = 2816;
  localparam int AW = $clog2(WORDS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata, rom_rdata;
  logic [AW-1:0] rom_addr;
  logic [31:0] mem [WORDS];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  otp_pkt_rd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata)
  );

  always_ff @(posedge clk) rom_rdata <= mem[rom_addr];

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic build(input int sizes[$]);
    int pos = 0;
    for (int i = 0; i < WORDS; i++) mem[i] = 32'h0;
    foreach (sizes[n]) begin
      mem[pos] = {16'(16'hBE00 + n), 8'(sizes[n]), 8'(n)};
      for (int j = 1; j <= sizes[n]; j++) mem[pos + j] = 32'(pos + j) * 32'h9E3779B1;
      pos += sizes[n] + 2;
    end
  endtask

  // walk of the chain by the requirements: k headers read, found, position, length
  task automatic model(input int tgt, output int k, output bit found, output int pos, output int len);
    pos = 0; k = 0; found = 0; len = 0;
    while (pos < WORDS) begin
      k++;
      len = int'(mem[pos][15:8]);
      if (len == 0) return;
      if (tgt < pos + len + 2) begin found = 1; return; end
      pos += len + 2;
    end
  endtask

  task automatic load(input int tgt, input bit meddle);
    int k, pos, len, n, j0;
    bit found;
    logic [31:0] d;
    model(tgt, k, found, pos, len);
    n = found ? 2 * k + len + 1 : 2 * k;
    wr(8'h04, {16'(tgt), 16'hFFFF});
    wr(8'h00, 32'h40);
    j0 = 1;
    if (meddle) begin
      wr(8'h04, 32'h0);        // R9 ignored while busy
      wr(8'h00, 32'h40);
      j0 = 3;
    end
    for (int j = j0; j <= n + 1; j++) begin
      rd(8'h0C, d);
      chk(d[6] == (j <= n), $sformatf("R8 busy cyc %0d tgt %0d", j, tgt), {31'h0, d[6]}, {31'h0, j <= n});
    end
    chk(d[0] == !found, "R7 err bit", {31'h0, d[0]}, {31'h0, !found});
    rd(8'h04, d);
    chk(d == {16'(tgt), 16'h0}, "R9 R2 mode readback", d, {16'(tgt), 16'h0});
    rd(8'h20, d);
    chk(d == (found ? mem[pos] : 32'h0), found ? "R4 header" : "R7 zero header", d, found ? mem[pos] : 32'h0);
    wr(8'h08, 32'h0);
    for (int i = 0; i < len + 2; i++) begin
      logic [31:0] e;
      e = (found && i < len) ? mem[pos + 1 + i] : 32'h0;
      rd(8'h24, d);
      chk(d == e, (found && i < len) ? "R5 payload" : "R6 past end", d, e);
    end
    rd(8'h08, d);
    chk(d == 32'(len + 2), "R5 index advance", d, 32'(len + 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    build('{3, 1, 5, 2});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(8'h04, d); chk(d == 0, "R1 mode", d, 0);
    rd(8'h08, d); chk(d == 0, "R1 index", d, 0);
    rd(8'h0C, d); chk(d == 0, "R1 status", d, 0);
    rd(8'h20, d); chk(d == 0, "R1 header", d, 0);
    // R2
    wr(8'h04, 32'h1234ABCD);
    rd(8'h04, d); chk(d == 32'h12340000, "R2 mode field", d, 32'h12340000);
    // R3 no start without bit 6
    wr(8'h00, 32'hFFFFFFBF);
    rd(8'h0C, d); chk(d == 0, "R3 no start", d, 0);
    // R3 R4 R5 R6 R8 on varied targets, including span edges
    load(0, 0);
    load(4, 0);
    load(5, 0);
    load(14, 0);
    load(18, 0);
    load(19, 0);   // R7 terminator
    load(5, 0);    // R7 error cleared
    load(500, 0);
    load(8, 1);    // R9
    build('{});
    load(0, 0);
    build('{255});
    load(100, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule